// File: doc/BRIEF.md
# Fixed-Point Adjustable Time Counter

This block keeps a 64-bit system time as a scaled fixed-point count. On every cycle where the reference tick input is high, the count grows by a programmable increment. The increment and a binary shift are chosen together for each of three link rates, so that nanoseconds come out of the raw count with a right shift alone. The nanosecond value is always available on a side output.

Software reaches the time through a small register port. The port has two 32-bit time halves and an increment word. Reading the low half captures the high half into a shadow register, so two 32-bit reads give one coherent 64-bit value. A frequency trim input takes a signed parts-per-billion request and scales the per-rate base increment up or down by that amount. The parameter `NARROW` selects one of two increment field widths: 31 bits, or 24 bits with a rescaled shift.

Top module: `fxt_time_counter`

## Requirements
- R1: After reset the time is zero and the shadow is zero. The increment word reads as the top-rate default: 0x66666666 for the wide variant, 0x01CCCCCC for the narrow one. The nanosecond output is zero.
- R2: On each clock where `tick_i` is high and no time half is written, the time grows by the current increment. With `tick_i` low and no write, the time holds.
- R3: The time wraps modulo 2^64.
- R4: A write to address 0 (low half) or address 1 (high half) replaces that half at the next clock edge. That write wins over a tick in the same cycle, and accumulation resumes from the written value.
- R5: A read of address 0 returns the low half and copies the high half into a shadow. A read of address 1 returns the shadow, not the live high half.
- R6: `speed_i` selects the rate. Code 0 (top rate) and code 3 (no link) load increment 0x66666666 with shift 28. Code 1 (middle rate) loads 0x40000000 with shift 24. Code 2 (low rate) loads 0x50000000 with shift 21. Any change of `speed_i` reloads the increment and the shift one clock later.
- R7: With `NARROW=1`, both the increments and the shifts of R6 are reduced by 7 bit positions. The increment field is 24 bits wide. The increment word reads with bit 24 set, above the 24-bit field.
- R8: `ns_o` equals the time shifted right by the current shift.
- R9: A trim request sets the increment to base ± floor(base × |ppb| / 10^9). The base is the default increment for the current rate, so successive trims do not compound. A negative request subtracts; a positive request adds.
- R10: The magnitude of a trim request is clamped to 250,000,000 ppb. This includes the most negative 32-bit value.
- R11: A write to address 2 loads the increment from the low field bits of the data; higher bits are dropped. Same-cycle priority for the increment is: rate change first, then trim, then register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Reference tick; time advances when high |
| speed_i | input | 2 | Link rate select (0 top, 1 middle, 2 low, 3 no link) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives the shadow capture) |
| addr_i | input | 2 | Register address: 0 time low, 1 time high, 2 increment word |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| trim_valid_i | input | 1 | Apply a frequency trim this cycle |
| trim_ppb_i | input | 32 | Signed trim request in parts per billion |
| ns_o | output | 64 | Time in nanoseconds (time >> shift) |

## Verification
The bench goes after the points where a design gets the scaling wrong:
- A wrap from all-ones past zero: a design that keeps the carry in the wrong half would show a nonzero high half.
- A high-half read after the time has moved on: a design without the shadow returns the live value.
- A write in the same cycle as a tick: the bench expects the written value, not the written value plus an increment.
- Rate changes on both field widths: a wrong shift shows up as a nanosecond value that differs between the variants, which should agree.
- Trims at ±10^6 ppb, at 300,000,000 ppb and at the most negative 32-bit value: a design that compounds trims or misses the clamp returns a different increment word.

// File: rtl/fxt_pkg.sv
package fxt_pkg;

    typedef enum logic [1:0] {
        SPD_TOP  = 2'd0,
        SPD_MID  = 2'd1,
        SPD_LOW  = 2'd2,
        SPD_IDLE = 2'd3
    } speed_e;

    localparam logic [1:0] ADDR_LO  = 2'd0;
    localparam logic [1:0] ADDR_HI  = 2'd1;
    localparam logic [1:0] ADDR_INC = 2'd2;

    localparam logic [31:0] RAW_INC_TOP = 32'h6666_6666;
    localparam logic [31:0] RAW_INC_MID = 32'h4000_0000;
    localparam logic [31:0] RAW_INC_LOW = 32'h5000_0000;
    localparam int          RAW_SH_TOP  = 28;
    localparam int          RAW_SH_MID  = 24;
    localparam int          RAW_SH_LOW  = 21;

endpackage

// File: rtl/fxt_rate_table.sv
module fxt_rate_table
    import fxt_pkg::*;
#(
    parameter int DROP  = 0,
    parameter int INC_W = 31,
    parameter int SH_W  = 5
) (
    input  speed_e             speed_i,
    output logic [INC_W-1:0]   base_o,
    output logic [SH_W-1:0]    shift_o
);

    logic [31:0] raw_inc;
    int          raw_sh;

    always_comb begin
        unique case (speed_i)
            SPD_MID: begin raw_inc = RAW_INC_MID; raw_sh = RAW_SH_MID; end
            SPD_LOW: begin raw_inc = RAW_INC_LOW; raw_sh = RAW_SH_LOW; end
            default: begin raw_inc = RAW_INC_TOP; raw_sh = RAW_SH_TOP; end
        endcase
    end

    logic [31:0] scaled_inc;
    assign scaled_inc = raw_inc >> DROP;
    assign base_o     = scaled_inc[INC_W-1:0];
    assign shift_o    = SH_W'(raw_sh - DROP);

    logic unused_scaled;
    assign unused_scaled = ^scaled_inc[31:INC_W];

endmodule

// File: rtl/fxt_freq_trim.sv
module fxt_freq_trim #(
    parameter int          INC_W     = 31,
    parameter int          PPB_W     = 32,
    parameter int unsigned PPB_LIMIT = 250_000_000
) (
    input  logic [INC_W-1:0]        base_i,
    input  logic signed [PPB_W-1:0] ppb_i,
    output logic [INC_W-1:0]        adj_o
);

    localparam int PW = 64;
    localparam logic [PW-1:0] BILLION = PW'(1_000_000_000);

    logic              neg;
    logic [PPB_W-1:0]  mag_raw;
    logic [PPB_W-1:0]  mag;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     diff;
    logic [PW-1:0]     adj_wide;

    always_comb begin
        neg      = ppb_i[PPB_W-1];
        mag_raw  = neg ? PPB_W'(-ppb_i) : PPB_W'(ppb_i);
        mag      = (mag_raw > PPB_W'(PPB_LIMIT)) ? PPB_W'(PPB_LIMIT) : mag_raw;
        prod     = PW'(base_i) * PW'(mag);
        diff     = prod / BILLION;
        adj_wide = neg ? (PW'(base_i) - diff) : (PW'(base_i) + diff);
    end

    assign adj_o = adj_wide[INC_W-1:0];

    logic unused_adj;
    assign unused_adj = ^adj_wide[PW-1:INC_W];

endmodule

// File: rtl/fxt_time_counter.sv
module fxt_time_counter
    import fxt_pkg::*;
#(
    parameter int          NARROW    = 0,
    parameter int          TIME_W    = 64,
    parameter int          REG_W     = 32,
    parameter int          PPB_W     = 32,
    parameter int unsigned PPB_LIMIT = 250_000_000
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic [1:0]          speed_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [1:0]          addr_i,
    input  logic [REG_W-1:0]    wdata_i,
    output logic [REG_W-1:0]    rdata_o,
    input  logic                trim_valid_i,
    input  logic [PPB_W-1:0]    trim_ppb_i,
    output logic [TIME_W-1:0]   ns_o
);

    localparam int INC_W  = (NARROW != 0) ? 24 : 31;
    localparam int DROP   = (NARROW != 0) ? 7 : 0;
    localparam int SH_W   = 5;
    localparam int PAD_W  = REG_W - INC_W;
    localparam logic [31:0]      TOP_SCALED = RAW_INC_TOP >> DROP;
    localparam logic [INC_W-1:0] TOP_BASE   = TOP_SCALED[INC_W-1:0];
    localparam logic [SH_W-1:0]  TOP_SH     = SH_W'(RAW_SH_TOP - DROP);

    typedef struct packed {
        logic [TIME_W-1:0] tm;
        logic [REG_W-1:0]  shadow;
        logic [INC_W-1:0]  inc;
        logic [SH_W-1:0]   shift;
        speed_e            spd;
    } state_t;

    state_t st_d, st_q;

    speed_e           speed_sel;
    logic [INC_W-1:0] tbl_base;
    logic [SH_W-1:0]  tbl_shift;
    logic [INC_W-1:0] trim_inc;

    assign speed_sel = speed_e'(speed_i);

    fxt_rate_table #(
        .DROP  (DROP),
        .INC_W (INC_W),
        .SH_W  (SH_W)
    ) rate_i (
        .speed_i (speed_sel),
        .base_o  (tbl_base),
        .shift_o (tbl_shift)
    );

    fxt_freq_trim #(
        .INC_W     (INC_W),
        .PPB_W     (PPB_W),
        .PPB_LIMIT (PPB_LIMIT)
    ) trim_i (
        .base_i (tbl_base),
        .ppb_i  (trim_ppb_i),
        .adj_o  (trim_inc)
    );

    logic wr_lo, wr_hi, wr_inc, rd_lo, speed_chg;

    always_comb begin
        wr_lo     = wr_en_i && (addr_i == ADDR_LO);
        wr_hi     = wr_en_i && (addr_i == ADDR_HI);
        wr_inc    = wr_en_i && (addr_i == ADDR_INC);
        rd_lo     = rd_en_i && (addr_i == ADDR_LO);
        speed_chg = (speed_sel != st_q.spd);

        st_d = st_q;

        if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.tm[REG_W-1:0]      = wdata_i;
            if (wr_hi) st_d.tm[TIME_W-1:REG_W] = wdata_i;
        end else if (tick_i) begin
            st_d.tm = st_q.tm + TIME_W'(st_q.inc);
        end

        if (rd_lo) st_d.shadow = st_q.tm[TIME_W-1:REG_W];

        if (speed_chg) begin
            st_d.inc   = tbl_base;
            st_d.shift = tbl_shift;
            st_d.spd   = speed_sel;
        end else if (trim_valid_i) begin
            st_d.inc = trim_inc;
        end else if (wr_inc) begin
            st_d.inc = wdata_i[INC_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.tm     <= '0;
            st_q.shadow <= '0;
            st_q.inc    <= TOP_BASE;
            st_q.shift  <= TOP_SH;
            st_q.spd    <= SPD_TOP;
        end else begin
            st_q <= st_d;
        end
    end

    logic [REG_W-1:0] inc_word;

    generate
        if (NARROW != 0) begin : g_narrow_word
            assign inc_word = {{(PAD_W-1){1'b0}}, 1'b1, st_q.inc};
        end else begin : g_wide_word
            assign inc_word = {{PAD_W{1'b0}}, st_q.inc};
        end
    endgenerate

    always_comb begin
        unique case (addr_i)
            ADDR_LO:  rdata_o = st_q.tm[REG_W-1:0];
            ADDR_HI:  rdata_o = st_q.shadow;
            ADDR_INC: rdata_o = inc_word;
            default:  rdata_o = '0;
        endcase
    end

    assign ns_o = st_q.tm >> st_q.shift;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i[REG_W-1:INC_W];

    // R2
    hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !wr_lo && !wr_hi) |=> $stable(st_q.tm));

    // R4
    low_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_lo |=> (st_q.tm[REG_W-1:0] == $past(wdata_i)));

    // R5
    shadow_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_lo |=> (st_q.shadow == $past(st_q.tm[TIME_W-1:REG_W])));

    // R6
    shift_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.shift == SH_W'(RAW_SH_TOP - DROP)) ||
        (st_q.shift == SH_W'(RAW_SH_MID - DROP)) ||
        (st_q.shift == SH_W'(RAW_SH_LOW - DROP)));

    // R10
    trim_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trim_valid_i && !speed_chg) |=>
        (({2'b00, st_q.inc} << 2) <= (({2'b00, $past(tbl_base)} << 2) + {2'b00, $past(tbl_base)})) &&
        (({2'b00, st_q.inc} << 2) >= (({2'b00, $past(tbl_base)} << 2) - {2'b00, $past(tbl_base)})));

endmodule

// File: tb/fxt_time_counter_tb.sv
module fxt_time_counter_tb_top;

    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [1:0]  speed;
    logic        wr_en, rd_en;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic        trim_valid;
    logic [31:0] trim_ppb;
    logic [31:0] rdata_w, rdata_n;
    logic [63:0] ns_w, ns_n;

    always #(PERIOD/2) clk = ~clk;

    fxt_time_counter #(.NARROW(0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .speed_i(speed),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata_w), .trim_valid_i(trim_valid), .trim_ppb_i(trim_ppb),
        .ns_o(ns_w));

    fxt_time_counter #(.NARROW(1)) dut_n_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .speed_i(speed),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata_n), .trim_valid_i(trim_valid), .trim_ppb_i(trim_ppb),
        .ns_o(ns_n));

    typedef struct {
        bit          nar;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // Monitor: pops every expectation pushed this cycle and compares.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (exp_q.size() > 0) begin
                exp_t it;
                logic [31:0] got;
                it  = exp_q.pop_front();
                got = it.nar ? rdata_n : rdata_w;
                total++;
                if (got !== it.exp) begin
                    bad++;
                    $display("FAIL %s (%s): got=%h expected=%h", it.tag,
                             it.nar ? "narrow" : "wide", got, it.exp);
                end
            end
        end
    end

    task automatic rd2(input logic [1:0] a, input logic [31:0] ew,
                       input logic [31:0] en, input string tag);
        exp_t iw, in_;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        iw.nar = 1'b0; iw.exp = ew; iw.tag = tag;
        in_.nar = 1'b1; in_.exp = en; in_.tag = tag;
        exp_q.push_back(iw);
        exp_q.push_back(in_);
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic trim(input logic [31:0] p);
        @(negedge clk);
        trim_ppb = p; trim_valid = 1'b1;
        @(posedge clk); #1 trim_valid = 1'b0;
    endtask

    task automatic set_speed(input logic [1:0] s);
        @(negedge clk);
        speed = s;
        @(posedge clk); #1;
    endtask

    task automatic check_ns(input logic [63:0] ew, input logic [63:0] en, input string tag);
        @(negedge clk);
        #5;
        total += 2;
        if (ns_w !== ew) begin
            bad++;
            $display("FAIL %s (wide ns): got=%h expected=%h", tag, ns_w, ew);
        end
        if (ns_n !== en) begin
            bad++;
            $display("FAIL %s (narrow ns): got=%h expected=%h", tag, ns_n, en);
        end
    endtask

    function automatic logic [31:0] trim_exp(input longint unsigned base, input int ppb);
        longint unsigned mag, d;
        mag = (ppb < 0) ? longint'(-longint'(ppb)) : longint'(ppb);
        if (mag > 250_000_000) mag = 250_000_000;
        d = (base * mag) / 1_000_000_000;
        return (ppb < 0) ? 32'(base - d) : 32'(base + d);
    endfunction

    localparam longint unsigned BW = 64'h6666_6666;
    localparam longint unsigned BN = 64'h00CC_CCCC;

    initial begin
        rst_n = 1'b0; tick = 1'b0; speed = 2'd0; wr_en = 1'b0; rd_en = 1'b0;
        addr = 2'd0; wdata = '0; trim_valid = 1'b0; trim_ppb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd2(2'd0, 32'h0, 32'h0, "R1 time low");
        rd2(2'd2, 32'h6666_6666, 32'h01CC_CCCC, "R1 increment word");
        check_ns(64'h0, 64'h0, "R1 ns");

        // R2 accumulation, R8 ns scaling
        ticks(5);
        check_ns(64'h1F, 64'h1F, "R8 ns after five ticks");
        rd2(2'd0, 32'hFFFF_FFFE, 32'h03FF_FFFC, "R2 low after five ticks");
        rd2(2'd1, 32'h1, 32'h0, "R5 high via shadow");

        // R5 shadow holds while time moves on
        ticks(1);
        rd2(2'd1, 32'h1, 32'h0, "R5 stale shadow");
        rd2(2'd0, 32'h6666_6664, 32'h04CC_CCC8, "R2 low after sixth tick");
        rd2(2'd1, 32'h2, 32'h0, "R5 fresh shadow");

        // R2 hold without tick
        repeat (3) @(negedge clk);
        rd2(2'd0, 32'h6666_6664, 32'h04CC_CCC8, "R2 hold");

        // R3 wrap
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFF0);
        ticks(1);
        rd2(2'd0, 32'h6666_6656, 32'h00CC_CCBC, "R3 wrap low");
        rd2(2'd1, 32'h0, 32'h0, "R3 wrap high");

        // R4 write beats tick
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 32'h100;
        @(posedge clk); #1 wr_en = 1'b0; tick = 1'b0;
        rd2(2'd0, 32'h100, 32'h100, "R4 write over tick");
        ticks(1);
        rd2(2'd0, 32'h6666_6766, 32'h00CC_CDCC, "R4 resume from written");

        // R6 middle rate, R7 narrow rescale
        set_speed(2'd1);
        rd2(2'd2, 32'h4000_0000, 32'h0180_0000, "R6 R7 middle increment");
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0);
        ticks(2);
        check_ns(64'h80, 64'h80, "R6 middle shift");

        // R6 low rate
        set_speed(2'd2);
        rd2(2'd2, 32'h5000_0000, 32'h01A0_0000, "R6 low increment");
        wr(2'd0, 32'h0);
        ticks(4);
        check_ns(64'hA00, 64'hA00, "R6 low shift");

        // R6 no-link code
        set_speed(2'd3);
        rd2(2'd2, 32'h6666_6666, 32'h01CC_CCCC, "R6 no-link increment");

        // R9 trim from base
        trim(32'd1_000_000);
        rd2(2'd2, trim_exp(BW, 1_000_000), 32'h0100_0000 | trim_exp(BN, 1_000_000), "R9 positive trim");
        trim(-32'sd1_000_000);
        rd2(2'd2, trim_exp(BW, -1_000_000), 32'h0100_0000 | trim_exp(BN, -1_000_000), "R9 negative trim no compound");

        // R10 clamp
        trim(32'd300_000_000);
        rd2(2'd2, 32'h7FFF_FFFF, 32'h01FF_FFFF, "R10 positive clamp");
        trim(32'h8000_0000);
        rd2(2'd2, trim_exp(BW, -250_000_000), 32'h0100_0000 | trim_exp(BN, -250_000_000), "R10 most negative clamp");

        // R11 increment write, masked
        wr(2'd2, 32'h9234_5678);
        rd2(2'd2, 32'h1234_5678, 32'h0134_5678, "R11 increment readback");
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0);
        ticks(2);
        rd2(2'd0, 32'h2468_ACF0, 32'h0068_ACF0, "R11 accumulate written increment");

        // R6 reload after manual write
        set_speed(2'd0);
        rd2(2'd2, 32'h6666_6666, 32'h01CC_CCCC, "R6 reload on change");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule